// File: doc/BRIEF.md
# Commit-Latched Backlight Pulse-Width Modulator

This block drives one pulse-width-modulated line for display backlight dimming. Software programs three counts through a small word-addressed register port: a prescaler that slows the input clock, a period count and a high-width count. Software converts time to counts. Written values sit in staging registers and leave the output untouched. Software then raises a commit bit. That captures all three counts at once, so brightness and frequency always change as one consistent pair.

The captured set becomes active only where the current output period ends, so the period in progress always runs to full length. One output period is (prescale+1)·(period+1) clock cycles. The output is high for the first (prescale+1)·(width+1) of those cycles. The width field is one bit wider than the period field. Any width at or above the period keeps the line high for the whole period. A run bit starts and stops the generator.

Top module: `bl_pwm_top`

## Requirements
- R1: The run control is bit 0 of byte address 0x00. While it is 0, `pwm_out` is low and the prescaler and period counters are held at zero.
- R2: A write to address 0x08 that takes bit 0 from 0 to 1 captures the staged prescale, period and width together. Staged writes with no such commit do not change the output waveform.
- R3: The prescale count is the 10-bit field at bits [25:16] of address 0x10.
- R4: At address 0x14, the period count is the 12-bit field at bits [11:0] and the width count is the 13-bit field at bits [28:16].
- R5: While running, one output period lasts (prescale+1)·(period+1) clock cycles, and every period begins with the output high.
- R6: When width < period, the output is high for the first (prescale+1)·(width+1) cycles of each period and low for the rest.
- R7: When width ≥ period, the output stays high for every cycle while running.
- R8: Committed values take effect at the first period boundary after the commit. The period in progress is neither shortened nor lengthened. While idle, they take effect on the next cycle.
- R9: In the cycle after the run bit changes from 0 to 1, a fresh period starts with the output high.
- R10: Reads return the staged values as written, and the run and commit bits at bit 0. Bits outside the defined fields read 0 and are not stored. Unmapped addresses read 0.
- R11: After reset, all registers read 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counters and registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe, one cycle per write |
| cfg_addr | input | 5 | Byte address of the register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| pwm_out | output | 1 | Modulated backlight output |

## Verification
The bench drives a commit into the middle of a running period. A design that loads the new counts at once would end that period early, and the bench would see the wrong number of high and total cycles before the next rising edge. It also writes new counts without committing them. A design that reads the staging registers directly would change the waveform there.

Width equal to the period, width far above it, and an all-zero configuration are each measured over a whole period. An off-by-one compare would drop the line low for a cycle. The bench writes all ones to every register and reads them back: a decoder that keeps reserved bits, or that aliases unmapped addresses, shows up in that readback. The bench also stops and restarts the generator. Counters left un-cleared would make the restart begin mid-period or low.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
   // Byte addresses; software depends on these.
   localparam int unsigned OFS_RUN      = 'h00;
   localparam int unsigned OFS_APPLY    = 'h08;
   localparam int unsigned OFS_PRESCALE = 'h10;
   localparam int unsigned OFS_SHAPE    = 'h14;

   // Field positions inside the words.
   localparam int unsigned LSB_PRESCALE = 16;
   localparam int unsigned LSB_PERIOD   = 0;
   localparam int unsigned LSB_WIDTH    = 16;

   // Default field widths.
   localparam int unsigned DEF_DIV_W = 10;
   localparam int unsigned DEF_PER_W = 12;
   localparam int unsigned DEF_WID_W = 13;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
   import bl_pwm_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DIV_W  = DEF_DIV_W,
   parameter int unsigned PER_W  = DEF_PER_W,
   parameter int unsigned WID_W  = DEF_WID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              run,
   output logic              commit_rise,
   output logic [DIV_W-1:0]  stg_div,
   output logic [PER_W-1:0]  stg_per,
   output logic [WID_W-1:0]  stg_wid
);
   localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(OFS_RUN);
   localparam logic [ADDR_W-1:0] A_APPLY = ADDR_W'(OFS_APPLY);
   localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'(OFS_PRESCALE);
   localparam logic [ADDR_W-1:0] A_SHAPE = ADDR_W'(OFS_SHAPE);

   logic run_q, apply_q;
   logic [DIV_W-1:0] div_q;
   logic [PER_W-1:0] per_q;
   logic [WID_W-1:0] wid_q;

   logic sel_run, sel_apply, sel_pre, sel_shape;
   assign sel_run   = wr_en && (addr == A_RUN);
   assign sel_apply = wr_en && (addr == A_APPLY);
   assign sel_pre   = wr_en && (addr == A_PRE);
   assign sel_shape = wr_en && (addr == A_SHAPE);

   // Reserved write bits are dropped here.
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         apply_q <= 1'b0;
         div_q   <= '0;
         per_q   <= '0;
         wid_q   <= '0;
      end else begin
         if (sel_run)   run_q   <= wdata[0];
         if (sel_apply) apply_q <= wdata[0];
         if (sel_pre)   div_q   <= wdata[LSB_PRESCALE +: DIV_W];
         if (sel_shape) begin
            per_q <= wdata[LSB_PERIOD +: PER_W];
            wid_q <= wdata[LSB_WIDTH +: WID_W];
         end
      end
   end

   assign commit_rise = sel_apply && wdata[0] && !apply_q;
   assign run     = run_q;
   assign stg_div = div_q;
   assign stg_per = per_q;
   assign stg_wid = wid_q;

   always_comb begin
      rdata = '0;
      if (addr == A_RUN) begin
         rdata[0] = run_q;
      end else if (addr == A_APPLY) begin
         rdata[0] = apply_q;
      end else if (addr == A_PRE) begin
         rdata[LSB_PRESCALE +: DIV_W] = div_q;
      end else if (addr == A_SHAPE) begin
         rdata[LSB_PERIOD +: PER_W] = per_q;
         rdata[LSB_WIDTH +: WID_W]  = wid_q;
      end
   end

   // R10: staged fields move only on a write to their own address
   p_stage_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(div_q) && $stable(per_q) && $stable(wid_q) && $stable(run_q)));
endmodule

// File: rtl/bl_pwm_shadow.sv
module bl_pwm_shadow #(
   parameter int unsigned DIV_W = 10,
   parameter int unsigned PER_W = 12,
   parameter int unsigned WID_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             commit_rise,
   input  logic             period_end,
   input  logic [DIV_W-1:0] stg_div,
   input  logic [PER_W-1:0] stg_per,
   input  logic [WID_W-1:0] stg_wid,
   output logic [DIV_W-1:0] act_div,
   output logic [PER_W-1:0] act_per,
   output logic [WID_W-1:0] act_wid
);
   logic             pend;
   logic [DIV_W-1:0] pnd_div;
   logic [PER_W-1:0] pnd_per;
   logic [WID_W-1:0] pnd_wid;
   logic             load;

   // Apply at a period boundary, or at once while idle.
   assign load = pend && (!run || period_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         pnd_div <= '0;
         pnd_per <= '0;
         pnd_wid <= '0;
         act_div <= '0;
         act_per <= '0;
         act_wid <= '0;
      end else begin
         if (load) begin
            act_div <= pnd_div;
            act_per <= pnd_per;
            act_wid <= pnd_wid;
         end
         if (commit_rise) begin
            pnd_div <= stg_div;
            pnd_per <= stg_per;
            pnd_wid <= stg_wid;
            pend    <= 1'b1;
         end else if (load) begin
            pend <= 1'b0;
         end
      end
   end

   // R8: active set is frozen inside a running period
   p_midperiod_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !period_end) |=> ($stable(act_div) && $stable(act_per) && $stable(act_wid)));
endmodule

// File: rtl/bl_pwm_prescale.sv
module bl_pwm_prescale #(
   parameter int unsigned DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt >= div);
   assign tick = run && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (wrap)      cnt <= '0;
      else                cnt <= cnt + 1'b1;
   end

   // R1: idle holds the prescaler at zero
   p_prescale_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
   // R5: count never passes the active prescale value
   p_prescale_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div);
endmodule

// File: rtl/bl_pwm_period.sv
module bl_pwm_period #(
   parameter int unsigned PER_W = 12,
   parameter int unsigned WID_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [PER_W-1:0] per,
   input  logic [WID_W-1:0] wid,
   output logic             period_end,
   output logic             pwm_hi
);
   logic [PER_W-1:0] qcnt;
   logic             last_step;

   assign last_step  = (qcnt >= per);
   assign period_end = tick && last_step;
   // Widening the count keeps a width above the period comparable.
   assign pwm_hi     = run && (WID_W'(qcnt) <= wid);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) qcnt <= '0;
      else if (tick) begin
         if (last_step) qcnt <= '0;
         else           qcnt <= qcnt + 1'b1;
      end
   end

   // R1: idle holds the period counter at zero
   p_period_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (qcnt == '0));
   // R5: count never passes the active period value
   p_period_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      qcnt <= per);
   // R7: width at or above period keeps the line high
   p_full_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (wid >= WID_W'(per))) |-> pwm_hi);
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
   import bl_pwm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DIV_W    = DEF_DIV_W,
   parameter int unsigned PER_W    = DEF_PER_W,
   parameter int unsigned WID_W    = DEF_WID_W,
   parameter bit          OUT_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              pwm_out
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (WID_W < PER_W) begin : g_bad_wid
      $error("width field must be at least as wide as period field");
   end
   if (LSB_PRESCALE + DIV_W > DATA_W) begin : g_bad_div
      $error("prescale field exceeds data word");
   end
   if (LSB_WIDTH + WID_W > DATA_W || LSB_PERIOD + PER_W > LSB_WIDTH) begin : g_bad_shape
      $error("shape word fields overlap or overflow");
   end
   if (ADDR_SPAN <= OFS_SHAPE) begin : g_bad_addr
      $error("address bus too narrow for register map");
   end

   logic             run, commit_rise, tick, period_end, pwm_hi;
   logic [DIV_W-1:0] stg_div, act_div;
   logic [PER_W-1:0] stg_per, act_per;
   logic [WID_W-1:0] stg_wid, act_wid;

   bl_pwm_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .run(run),
      .commit_rise(commit_rise), .stg_div(stg_div),
      .stg_per(stg_per), .stg_wid(stg_wid)
   );

   bl_pwm_shadow #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) i_shadow (
      .clk(clk), .rst_n(rst_n), .run(run), .commit_rise(commit_rise),
      .period_end(period_end), .stg_div(stg_div), .stg_per(stg_per),
      .stg_wid(stg_wid), .act_div(act_div), .act_per(act_per),
      .act_wid(act_wid)
   );

   bl_pwm_prescale #(.DIV_W(DIV_W)) i_prescale (
      .clk(clk), .rst_n(rst_n), .run(run), .div(act_div), .tick(tick)
   );

   bl_pwm_period #(.PER_W(PER_W), .WID_W(WID_W)) i_period (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .per(act_per), .wid(act_wid), .period_end(period_end),
      .pwm_hi(pwm_hi)
   );

   if (OUT_FLOP) begin : g_out_flop
      logic out_q;
      always_ff @(posedge clk) begin
         if (!rst_n) out_q <= 1'b0;
         else        out_q <= pwm_hi;
      end
      assign pwm_out = out_q;
   end else begin : g_out_comb
      assign pwm_out = pwm_hi;
      // R1: output low while stopped
      p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !run |-> !pwm_out);
   end

   // R9: a restart opens a period with the line high
   p_fresh_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> pwm_hi);
endmodule

// File: tb/test_bl_pwm_top.sv
module test_bl_pwm_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 7;

   localparam logic [9:0]  V_DIV [NV] = '{10'd0, 10'd1, 10'd2, 10'd0, 10'd1, 10'd0, 10'd3};
   localparam logic [11:0] V_PER [NV] = '{12'd9, 12'd9, 12'd5, 12'd7, 12'd4, 12'd0, 12'd15};
   localparam logic [12:0] V_WID [NV] = '{13'd4, 13'd3, 13'd0, 13'd7, 13'h1FFF, 13'd0, 13'd14};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bl_pwm_top i_bl_pwm_top (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pwm_out(pwm_out)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Called at a negedge; returns at the negedge after the write edge.
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   // Sample index 0..len-1 of a period, then index len.
   task automatic measure(input int len, output int hi, output logic firstv,
                          output logic lastv, output logic nextv);
      hi = 0; firstv = pwm_out; lastv = 1'b0;
      for (int i = 0; i < len; i++) begin
         if (pwm_out) hi++;
         if (i == len - 1) lastv = pwm_out;
         @(negedge clk);
      end
      nextv = pwm_out;
   endtask

   task automatic align_rise();
      logic prev;
      do begin
         prev = pwm_out;
         @(negedge clk);
      end while (!(pwm_out && !prev));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      int hi, len, exp_hi, low_cnt;
      logic f, l, n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      check("R11 out after reset", pwm_out, 0);
      rd(5'h00, rv); check("R11 run reg", rv, 0);
      rd(5'h08, rv); check("R11 commit reg", rv, 0);
      rd(5'h10, rv); check("R11 prescale reg", rv, 0);
      rd(5'h14, rv); check("R11 shape reg", rv, 0);
      @(negedge clk);

      // R3 R4 R5 R6 R7 R9: vector walk
      for (int v = 0; v < NV; v++) begin
         wr(5'h00, 32'h0);
         wr(5'h10, {6'h0, V_DIV[v], 16'h0});
         wr(5'h14, {3'h0, V_WID[v], 4'h0, V_PER[v]});
         wr(5'h08, 32'h1);
         wr(5'h08, 32'h0);
         wr(5'h00, 32'h1);
         len = (int'(V_DIV[v]) + 1) * (int'(V_PER[v]) + 1);
         if (int'(V_WID[v]) >= int'(V_PER[v])) exp_hi = len;
         else exp_hi = (int'(V_DIV[v]) + 1) * (int'(V_WID[v]) + 1);
         measure(len, hi, f, l, n);
         check($sformatf("R9 start high v%0d", v), f, 1);
         if (exp_hi == len)
            check($sformatf("R7 full high count v%0d", v), hi, exp_hi);
         else
            check($sformatf("R6 high count v%0d", v), hi, exp_hi);
         check($sformatf("R5 last cycle level v%0d", v), l, (exp_hi == len) ? 1 : 0);
         check($sformatf("R5 next period high v%0d", v), n, 1);
      end

      // Config A: prescale 1, period 9, width 3 -> 20 cycles, 8 high
      wr(5'h00, 32'h0);
      wr(5'h10, 32'h0001_0000);
      wr(5'h14, 32'h0003_0009);
      wr(5'h08, 32'h1);
      wr(5'h08, 32'h0);
      wr(5'h00, 32'h1);

      // R2: stage config B (prescale 0, period 5, width 1) without commit
      wr(5'h10, 32'h0);
      wr(5'h14, 32'h0001_0005);
      align_rise();
      measure(20, hi, f, l, n);
      check("R2 uncommitted high count", hi, 8);
      check("R2 uncommitted last low", l, 0);
      check("R2 uncommitted next high", n, 1);

      // R8: commit at index 0..1; old period runs on to index 19
      wr(5'h08, 32'h1);
      wr(5'h08, 32'h0);
      measure(18, hi, f, l, n);
      check("R8 old period rest high count", hi, 6);
      check("R8 old period last low", l, 0);
      check("R8 boundary high", n, 1);
      measure(6, hi, f, l, n);
      check("R8 new high count", hi, 2);
      check("R8 new last low", l, 0);
      check("R8 new next high", n, 1);

      // R10: readback and reserved bits
      rd(5'h10, rv); check("R10 prescale readback", rv, 32'h0);
      rd(5'h14, rv); check("R10 shape readback", rv, 32'h0001_0005);
      rd(5'h00, rv); check("R10 run readback", rv, 32'h1);
      @(negedge clk);
      wr(5'h10, 32'hFFFF_FFFF);
      rd(5'h10, rv); check("R10 prescale reserved", rv, 32'h03FF_0000);
      @(negedge clk);
      wr(5'h14, 32'hFFFF_FFFF);
      rd(5'h14, rv); check("R10 shape reserved", rv, 32'h1FFF_0FFF);
      @(negedge clk);
      wr(5'h08, 32'hFFFF_FFFE);
      rd(5'h08, rv); check("R10 commit reserved", rv, 32'h0);
      @(negedge clk);
      wr(5'h04, 32'hFFFF_FFFF);
      rd(5'h04, rv); check("R10 unmapped", rv, 32'h0);
      @(negedge clk);

      // R1: stop
      wr(5'h00, 32'h0);
      low_cnt = 0;
      for (int i = 0; i < 10; i++) begin
         if (!pwm_out) low_cnt++;
         @(negedge clk);
      end
      check("R1 low while stopped", low_cnt, 10);

      // R9: restart gives a fresh config-B period (all-ones still uncommitted)
      wr(5'h00, 32'h1);
      measure(6, hi, f, l, n);
      check("R9 restart high", f, 1);
      check("R9 restart high count", hi, 2);
      check("R9 restart next high", n, 1);

      // R11: reset while running
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R11 out after mid reset", pwm_out, 0);
      rd(5'h00, rv); check("R11 run after mid reset", rv, 0);
      rd(5'h14, rv); check("R11 shape after mid reset", rv, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule